// File: doc/BRIEF.md
# SDRAM Bank Command Legality Tracker

This block follows one bank of an SDRAM device by watching the command lines at each rising clock edge. It keeps a copy of the bank's state and raises a one-cycle flag whenever a command aimed at this bank is not allowed in that state. A memory controller or a bus monitor can place one instance per bank to catch protocol violations as they happen. Each instance is set to its own bank number with a parameter.

The bank moves between eight states. Some of them are timed transitional states that end on their own: row opening, precharging, and the two auto-precharge bursts. While the bank is in one of these, only a no-op or an inhibit is acceptable. A plain read or write burst can be cut short by a new burst, by a precharge, or by a burst stop. If none of these arrives, the burst ends by itself after the burst length. The row-to-column delay, the precharge time and the burst length are parameters counted in clock cycles, and each must be at least 2.

Top module: `sdram_bank_tracker`

## Requirements
- R1: The `bank_state` output is encoded as 0 Idle, 1 Opening, 2 Open, 3 Reading, 4 Writing, 5 Reading-then-closing, 6 Writing-then-closing, 7 Closing. A synchronous active-high reset gives state 0 and `illegal` low. With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 no-op. With `cs_n` high the command is an inhibit.
- R2: In Idle, an activate moves the bank to Opening. Refresh, mode load and precharge are accepted and leave the bank in Idle. A read, write or burst stop is flagged.
- R3: An activate registered at edge e shows Opening after edges e through e+TRCD-2 and Open from edge e+TRCD-1. A read at edge e+TRCD is accepted. Any command other than no-op or inhibit in Opening is flagged.
- R4: A precharge registered at edge e shows Closing until edge e+TRP-1, from which the bank is Idle. An activate at edge e+TRP is accepted, while one at e+TRP-1 is flagged.
- R5: A read or write with `ap_flag` high starts the matching closing-burst state. After edge e+BL+TRP-1 the bank is Idle. Any command other than no-op or inhibit during these states is flagged.
- R6: In Open, a read or write (the state chosen by `ap_flag`) and a precharge are accepted. An activate, refresh, mode load or burst stop is flagged.
- R7: A read or write with `ap_flag` low registered at edge e shows Reading or Writing, and the bank returns to Open from edge e+BL-1.
- R8: During Reading or Writing, a new read or write restarts a burst, a precharge moves the bank to Closing, and a burst stop returns it to Open. An activate, refresh or mode load is flagged.
- R9: A flagged command leaves the state unchanged. `illegal` is high for exactly the one cycle after the edge that registered the command.
- R10: A command whose `bank` differs from BANK_ID is ignored and never flagged. The exceptions are precharge with `ap_flag` high (all banks), refresh and mode load, which apply to every bank.
- R11: When `cke` is low, the command lines are ignored and nothing is flagged, but the timed states still count down.
- R12: A no-op or an inhibit is accepted in every state and never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; commands are sampled only while it is high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BANK_W | Bank address of the command |
| ap_flag | input | 1 | Auto-precharge for read/write; all-banks for precharge |
| bank_state | output | 3 | Current bank state (R1 encoding) |
| illegal | output | 1 | One-cycle pulse for a disallowed command |

## Verification
The assertions assume that the TRCD, TRP and BL parameters are all at least 2, so that every timed state lasts at least one visible cycle. They also assume that the command lines are held stable around each clock edge. The bench uses the small values TRCD=3, TRP=3 and BL=4, and it changes inputs only one nanosecond after the rising edge. These values mean that the sweep command, issued one edge after a state is reached, always lands before any timer expires. Because of this, the expected next state in the sweep depends only on the state, the command, the bank match and the flag.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPEN = 3'd1,
    ST_ROW  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4,
    ST_RDC  = 3'd5,
    ST_WRC  = 3'd6,
    ST_CLS  = 3'd7
  } bank_st_e;

  typedef enum logic [3:0] {
    C_MODE = 4'd0,
    C_REF  = 4'd1,
    C_PRE  = 4'd2,
    C_ACT  = 4'd3,
    C_WR   = 4'd4,
    C_RD   = 4'd5,
    C_STOP = 4'd6,
    C_NOP  = 4'd7,
    C_INH  = 4'd8
  } cmd_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = C_INH;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = C_MODE;
        3'b001:  cmd = C_REF;
        3'b010:  cmd = C_PRE;
        3'b011:  cmd = C_ACT;
        3'b100:  cmd = C_WR;
        3'b101:  cmd = C_RD;
        3'b110:  cmd = C_STOP;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_trk_timer.sv
module sdram_trk_timer #(
  parameter int CNT_W = 4,
  parameter int MAXV  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // R5: no loaded interval may exceed the longest timed state
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= MAXV);

  // R11: the count keeps falling without a new load
  assert_cnt_falls_R11: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (int'(cnt) == int'($past(cnt)) - 1));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 0,
  parameter int TRCD    = 3,
  parameter int TRP     = 3,
  parameter int BL      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap_flag,
  output logic [2:0]        bank_state,
  output logic              illegal
);

  localparam int MAXV  = BL + TRP - 2;
  localparam int CNT_W = $clog2(BL + TRP + TRCD + 1);
  localparam logic [CNT_W-1:0] L_OPEN  = CNT_W'(TRCD - 2);
  localparam logic [CNT_W-1:0] L_CLOSE = CNT_W'(TRP - 2);
  localparam logic [CNT_W-1:0] L_BURST = CNT_W'(BL - 2);
  localparam logic [CNT_W-1:0] L_BCLS  = CNT_W'(BL + TRP - 2);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  cmd_e             cmd;
  bank_st_e         state, nxt;
  logic             hit, legal, load, tmr_zero, timed;
  logic [CNT_W-1:0] load_val;

  sdram_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdram_trk_timer #(.CNT_W(CNT_W), .MAXV(MAXV)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    hit = cke && (cmd != C_NOP) && (cmd != C_INH) &&
          ((bank == MY_BANK) || (cmd == C_PRE && ap_flag) ||
           (cmd == C_REF) || (cmd == C_MODE));
    timed = (state == ST_OPEN) || (state == ST_CLS) || (state == ST_RD) ||
            (state == ST_WR) || (state == ST_RDC) || (state == ST_WRC);
  end

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    legal    = 1'b1;
    if (timed && tmr_zero) begin
      case (state)
        ST_OPEN, ST_RD, ST_WR: nxt = ST_ROW;
        default:               nxt = ST_IDLE;
      endcase
    end
    if (hit) begin
      legal = 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd == C_ACT) begin
            legal = 1'b1; nxt = ST_OPEN; load = 1'b1; load_val = L_OPEN;
          end else if (cmd == C_REF || cmd == C_MODE || cmd == C_PRE) begin
            legal = 1'b1;
          end
        end
        ST_ROW, ST_RD, ST_WR: begin
          if (cmd == C_RD || cmd == C_WR) begin
            legal = 1'b1;
            load  = 1'b1;
            if (ap_flag) begin
              nxt = (cmd == C_RD) ? ST_RDC : ST_WRC; load_val = L_BCLS;
            end else begin
              nxt = (cmd == C_RD) ? ST_RD : ST_WR; load_val = L_BURST;
            end
          end else if (cmd == C_PRE) begin
            legal = 1'b1; nxt = ST_CLS; load = 1'b1; load_val = L_CLOSE;
          end else if (cmd == C_STOP && state != ST_ROW) begin
            legal = 1'b1; nxt = ST_ROW;
          end
        end
        default: legal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      illegal <= 1'b0;
    end else begin
      state   <= nxt;
      illegal <= hit && !legal;
    end
  end

  assign bank_state = state;

  // R3: opening ends only in the open state
  assert_open_hold_R3: assert property (@(posedge clk) disable iff (rst)
    state == ST_OPEN |=> (state == ST_OPEN || state == ST_ROW));

  // R4: closing ends only in idle
  assert_close_hold_R4: assert property (@(posedge clk) disable iff (rst)
    state == ST_CLS |=> (state == ST_CLS || state == ST_IDLE));

  // R5: closing bursts cannot be interrupted
  assert_rdc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    state == ST_RDC |=> (state == ST_RDC || state == ST_IDLE));
  assert_wrc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    state == ST_WRC |=> (state == ST_WRC || state == ST_IDLE));

  // R2: idle only leaves toward opening
  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |=> (state == ST_IDLE || state == ST_OPEN));

  // R11: a flag needs a sampled, selected command
  assert_flag_cause_R11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(cke && !cs_n));

endmodule

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;

  localparam int TRCD = 3;
  localparam int TRP  = 3;
  localparam int BL   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bank = 2'd0;
  logic ap_flag = 1'b0;
  logic [2:0] bank_state;
  logic illegal;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sdram_bank_tracker #(.BANK_W(2), .BANK_ID(0), .TRCD(TRCD), .TRP(TRP), .BL(BL)) u_dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank(bank), .ap_flag(ap_flag), .bank_state(bank_state),
    .illegal(illegal)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // command codes: 0..7 = {ras_n,cas_n,we_n} with cs_n low, 8 = inhibit
  task automatic cyc(input int c, input int b, input bit a, input bit ke);
    cs_n = (c == 8);
    {ras_n, cas_n, we_n} = 3'(c);
    bank = 2'(b);
    ap_flag = a;
    cke = ke;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();
    cyc(7, 0, 1'b0, 1'b1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    nop();
    nop();
    rst = 1'b0;
  endtask

  task automatic reach(input int s);
    do_reset();
    case (s)
      1: cyc(3, 0, 1'b0, 1'b1);
      2: begin cyc(3, 0, 1'b0, 1'b1); nop(); nop(); end
      3: begin cyc(3, 0, 1'b0, 1'b1); nop(); nop(); cyc(5, 0, 1'b0, 1'b1); end
      4: begin cyc(3, 0, 1'b0, 1'b1); nop(); nop(); cyc(4, 0, 1'b0, 1'b1); end
      5: begin cyc(3, 0, 1'b0, 1'b1); nop(); nop(); cyc(5, 0, 1'b1, 1'b1); end
      6: begin cyc(3, 0, 1'b0, 1'b1); nop(); nop(); cyc(4, 0, 1'b1, 1'b1); end
      7: begin cyc(3, 0, 1'b0, 1'b1); nop(); nop(); cyc(2, 0, 1'b0, 1'b1); end
      default: ;
    endcase
  endtask

  function automatic int applies(input int c, input int b, input bit a);
    if (c == 7 || c == 8) return 0;
    return (b == 0) || (c == 2 && a) || c == 1 || c == 0;
  endfunction

  // returns next state, or -1 when flagged
  function automatic int exp_next(input int s, input int c, input bit a);
    case (s)
      0: begin
        if (c == 3) return 1;
        if (c == 0 || c == 1 || c == 2) return 0;
        return -1;
      end
      2, 3, 4: begin
        if (c == 5) return a ? 5 : 3;
        if (c == 4) return a ? 6 : 4;
        if (c == 2) return 7;
        if (c == 6 && s != 2) return 2;
        return -1;
      end
      default: return -1;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    string tag;
    int e;
    do_reset();
    check("R1 reset state", bank_state, 0);
    check("R1 reset flag", illegal, 0);

    // sweep: every state x every command x bank x flag
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 9; c++) begin
        for (int b = 0; b < 2; b++) begin
          for (int a = 0; a < 2; a++) begin
            reach(s);
            check("R1 reach state", bank_state, s);
            cyc(c, b, 1'(a), 1'b1);
            if (c == 7 || c == 8) tag = "R12";
            else if (b != 0) tag = "R10";
            else if (s == 0) tag = "R2";
            else if (s == 2) tag = "R6";
            else if (s == 3 || s == 4) tag = "R8";
            else if (s == 1) tag = "R3";
            else if (s == 7) tag = "R4";
            else tag = "R5";
            if (applies(c, b, 1'(a)) != 0) e = exp_next(s, c, 1'(a));
            else e = s;
            check({tag, " flag"}, illegal, (e < 0) ? 1 : 0);
            check({tag, " state R9"}, bank_state, (e < 0) ? s : e);
          end
        end
      end
    end

    // R3 timing
    reach(1);
    check("R3 opening e", bank_state, 1);
    nop();
    check("R3 opening e+1", bank_state, 1);
    nop();
    check("R3 open at e+TRCD-1", bank_state, 2);
    cyc(5, 0, 1'b0, 1'b1);
    check("R3 read at e+TRCD legal", illegal, 0);
    reach(1);
    nop();
    cyc(5, 0, 1'b0, 1'b1);
    check("R3 read at e+TRCD-1 flagged", illegal, 1);
    check("R3 state after early read", bank_state, 2);
    nop();
    check("R9 flag one cycle", illegal, 0);

    // R4 timing
    reach(7);
    nop();
    check("R4 closing", bank_state, 7);
    cyc(3, 0, 1'b0, 1'b1);
    check("R4 early activate flagged", illegal, 1);
    check("R4 idle at e+TRP-1", bank_state, 0);
    reach(7);
    nop();
    nop();
    cyc(3, 0, 1'b0, 1'b1);
    check("R4 activate at e+TRP", illegal, 0);
    check("R4 opening after activate", bank_state, 1);

    // R5 timing, read and write with closing
    for (int w = 0; w < 2; w++) begin
      reach(5 + w);
      for (int k = 1; k < BL + TRP - 1; k++) begin
        nop();
        check("R5 closing burst held", bank_state, 5 + w);
      end
      nop();
      check("R5 idle at e+BL+TRP-1", bank_state, 0);
    end

    // R7 timing
    for (int w = 0; w < 2; w++) begin
      reach(3 + w);
      nop();
      check("R7 burst held", bank_state, 3 + w);
      nop();
      check("R7 burst held", bank_state, 3 + w);
      nop();
      check("R7 open at e+BL-1", bank_state, 2);
    end

    // R11 clock enable low
    do_reset();
    cyc(5, 0, 1'b0, 1'b0);
    check("R11 ignored in idle flag", illegal, 0);
    check("R11 ignored in idle state", bank_state, 0);
    cyc(3, 0, 1'b0, 1'b1);
    cyc(5, 0, 1'b0, 1'b0);
    check("R11 no flag while opening", illegal, 0);
    cyc(5, 0, 1'b0, 1'b0);
    check("R11 timer runs with cke low", bank_state, 2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule